// File: doc/BRIEF.md
# Vectored interrupt flag controller

This block gathers eighteen peripheral interrupt lines into one CPU-visible flag register. Each source has an enable bit, and a single global enable sits over all of them. When at least one flag is both set and enabled, and the global enable is on, the block raises a request to the processor core. With that request it presents the code address of the service routine for the winning source. The vectors start at 03h and are spaced eight bytes apart.

Software reads the flag, enable and global-enable state from output ports. It changes them through a small write port with four selectable actions: set flags, clear flags, load enables, and load the global enable. When the core enters a routine, it pulses an acknowledge together with the number of the source it is serving. Sources of the hardware-cleared kind then drop their flag on their own. Every other source keeps its flag until software clears it.

Each source is either edge-captured or level-followed. An edge source sets its flag once per rising edge. A level source sets its flag again on every cycle that its line is high.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, flag_o, en_o and gie_o are all zero and irq_o is low.
- R2: For an edge source (every source except 6, 13 and 15), a 0-to-1 transition of its src_i bit sets its flag one clock later. A line that stays high does not set the flag again after the flag is cleared.
- R3: For a level source (6, 13 and 15), the flag is set on every clock in which its src_i bit is high, so a software clear has no effect while the line is high. Once the line is low, a software clear takes effect.
- R4: irq_o is high exactly when gie_o is 1 and some bit is set in both flag_o and en_o.
- R5: The vector is 03h + 8·n, where n is the lowest-numbered source that has both its flag and its enable set. Source 0 gives 03h and source 17 gives 8Bh.
- R6: An acknowledge pulse with number k clears flag k only if k is one of 0, 1, 2, 3, 9, 10, 11 or 12. It leaves every other flag unchanged. For any other k, including numbers 18 and above, no flag changes.
- R7: The write port acts on the clock edge where wr_en_i is high. Select 0 sets the flags marked by ones in wr_data_i. Select 1 clears the flags marked by ones. Select 2 loads the enables from wr_data_i. Select 3 loads the global enable from wr_data_i bit 0.
- R8: A hardware set of a flag, whether from an edge or a level, takes precedence over a software clear or an acknowledge clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_i | input | 18 | Raw peripheral interrupt lines |
| wr_en_i | input | 1 | Write strobe for the software port |
| wr_sel_i | input | 2 | Write action: 0 set flags, 1 clear flags, 2 load enables, 3 load global enable |
| wr_data_i | input | 18 | Write data or bit mask |
| ack_i | input | 1 | Core acknowledge pulse on entering a routine |
| ack_src_i | input | 5 | Number of the source being acknowledged |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 8 | Vector address of the winning source |
| flag_o | output | 18 | Flag register contents |
| en_o | output | 18 | Enable register contents |
| gie_o | output | 1 | Global enable |

## Verification
The bench sets every flag and then acknowledges every number from 0 to 19. This exposes a wrong hardware-clear set, an acknowledge that clears more than one flag, and an out-of-range number that aliases onto a real source. It sweeps the winner from each source up to 17 under full and partial enable masks, so an inverted priority or a miscounted vector stride shows up as a wrong address. It also drives a rising edge, a software clear and an acknowledge in the same cycle. A design that lets the clear win would lose that edge. Finally, it holds edge and level lines high across a clear, which catches an edge source that retriggers and a level source that can be cleared while still asserted.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NSRC     = 18,
  parameter int VW       = 8,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8,
  parameter logic [NSRC-1:0] HWCLR_MASK = 18'h01E0F,
  parameter logic [NSRC-1:0] EDGE_MASK  = 18'h35FBF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_sel_i,
  input  logic [NSRC-1:0] wr_data_i,
  input  logic            ack_i,
  input  logic [$clog2(NSRC)-1:0] ack_src_i,
  output logic            irq_o,
  output logic [VW-1:0]   vec_o,
  output logic [NSRC-1:0] flag_o,
  output logic [NSRC-1:0] en_o,
  output logic            gie_o
);
  localparam int IW = $clog2(NSRC);

  logic [NSRC-1:0] flag_q, en_q, src_q;
  logic            gie_q;
  logic [NSRC-1:0] hw_set, sw_set, sw_clr, ack_clr, pending;
  logic [IW-1:0]   win;
  logic            any;

  assign hw_set  = (EDGE_MASK & src_i & ~src_q) | (~EDGE_MASK & src_i);
  assign sw_set  = (wr_en_i && wr_sel_i == 2'd0) ? wr_data_i : '0;
  assign sw_clr  = (wr_en_i && wr_sel_i == 2'd1) ? wr_data_i : '0;
  assign pending = flag_q & en_q;

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      ack_clr[i] = ack_i && (ack_src_i == IW'(i)) && HWCLR_MASK[i];
  end

  always_comb begin
    win = '0;
    any = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pending[i]) begin
        win = IW'(i);
        any = 1'b1;
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      src_q  <= '0;
      gie_q  <= 1'b0;
    end else begin
      src_q  <= src_i;
      flag_q <= (flag_q & ~sw_clr & ~ack_clr) | sw_set | hw_set;
      if (wr_en_i && wr_sel_i == 2'd2) en_q  <= wr_data_i;
      if (wr_en_i && wr_sel_i == 2'd3) gie_q <= wr_data_i[0];
    end
  end

  assign irq_o  = gie_q & any;
  assign vec_o  = VW'(VEC_BASE + VEC_STEP * int'(win));
  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign gie_o  = gie_q;

  logic [VW-1:0] vidx;
  assign vidx = (vec_o - VW'(VEC_BASE)) / VW'(VEC_STEP);

  // R2
  edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((EDGE_MASK & src_i & ~src_q) != '0) |=>
      ((flag_q & $past(EDGE_MASK & src_i & ~src_q)) == $past(EDGE_MASK & src_i & ~src_q)));

  // R3
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~EDGE_MASK & src_i) != '0) |=>
      ((flag_q & $past(~EDGE_MASK & src_i)) == $past(~EDGE_MASK & src_i)));

  // R6
  sw_only_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && wr_sel_i == 2'd1) |=> ((($past(flag_q) & ~flag_q) & ~HWCLR_MASK) == '0));

  // R4
  gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_o |-> !irq_o);

  // R5
  vec_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vidx < VW'(NSRC)) && flag_o[vidx[IW-1:0]] && en_o[vidx[IW-1:0]]);

  // R5
  vec_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((flag_o & en_o & ((NSRC'(1) << vidx) - NSRC'(1))) == '0));
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  logic        clk = 0, rst_n = 0;
  logic [17:0] src_i = '0, wr_data_i = '0;
  logic        wr_en_i = 0, ack_i = 0;
  logic [1:0]  wr_sel_i = '0;
  logic [4:0]  ack_src_i = '0;
  logic        irq_o, gie_o;
  logic [7:0]  vec_o;
  logic [17:0] flag_o, en_o;
  int nchk = 0, nfail = 0;
  bit done = 0;
  localparam logic [17:0] ALL = 18'h3FFFF;

  irq_vector_ctrl u_dut (.clk, .rst_n, .src_i, .wr_en_i, .wr_sel_i, .wr_data_i,
    .ack_i, .ack_src_i, .irq_o, .vec_o, .flag_o, .en_o, .gie_o);

  always #5 clk = ~clk;

  function automatic bit is_hw(int n);
    return n inside {0, 1, 2, 3, 9, 10, 11, 12};
  endfunction
  function automatic bit is_lvl(int n);
    return n inside {6, 13, 15};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [17:0] d);
    wr_en_i = 1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 0; wr_data_i = '0;
  endtask

  task automatic ack(input int k);
    ack_i = 1; ack_src_i = 5'(k);
    @(negedge clk);
    ack_i = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 flags", flag_o, 0); chk("R1 en", en_o, 0);
    chk("R1 gie", gie_o, 0); chk("R1 irq", irq_o, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq after release", irq_o, 0);

    // R7
    wr(2, 18'h2A5A5); chk("R7 enable load", en_o, 18'h2A5A5);
    wr(3, 18'h1); chk("R7 gie set", gie_o, 1);
    wr(2, ALL);

    // R5 R4 R7: single source sweep
    for (int n = 0; n < 18; n++) begin
      wr(0, 18'(1) << n);
      chk("R7 sw set", flag_o, 18'(1) << n);
      chk("R4 irq on", irq_o, 1);
      chk("R5 vector", vec_o, 3 + 8 * n);
      wr(3, 0); chk("R4 gie off", irq_o, 0);
      wr(3, 1);
      wr(1, ALL); chk("R7 sw clear", flag_o, 0);
      chk("R4 irq none", irq_o, 0);
    end

    // R5 priority sweep
    wr(0, ALL);
    for (int n = 0; n < 18; n++) begin
      chk("R5 lowest wins", vec_o, 3 + 8 * n);
      wr(1, 18'(1) << n);
    end
    chk("R4 empty", irq_o, 0);

    // R5 R4 enable masking
    wr(0, ALL);
    for (int n = 0; n < 18; n++) begin
      wr(2, ALL << n);
      chk("R5 masked lowest", vec_o, 3 + 8 * n);
      chk("R4 masked irq", irq_o, 1);
    end
    wr(2, 0); chk("R4 no enables", irq_o, 0);
    wr(2, ALL); wr(1, ALL);

    // R6 ack sweep
    for (int k = 0; k < 20; k++) begin
      logic [17:0] exp;
      wr(0, ALL);
      ack(k);
      exp = (k < 18 && is_hw(k)) ? (ALL & ~(18'(1) << k)) : ALL;
      chk("R6 ack clear", flag_o, exp);
      wr(1, ALL);
    end

    // R2 R3 hold across clear
    for (int n = 0; n < 18; n++) begin
      src_i[n] = 1'b1;
      @(negedge clk);
      chk("R2/R3 source sets", flag_o, 18'(1) << n);
      @(negedge clk);
      wr(1, ALL);
      chk(is_lvl(n) ? "R3 level held" : "R2 edge once", flag_o,
          is_lvl(n) ? (18'(1) << n) : 0);
      src_i[n] = 1'b0;
      @(negedge clk);
      wr(1, ALL);
      chk("R3 clear after drop", flag_o, 0);
    end

    // R8 edge beats same-cycle clears
    src_i[2] = 1; wr_en_i = 1; wr_sel_i = 1; wr_data_i = ALL; ack_i = 1; ack_src_i = 2;
    @(negedge clk);
    wr_en_i = 0; ack_i = 0;
    chk("R8 edge beats clear", flag_o, 18'h4);
    src_i[2] = 0;
    wr(1, ALL);
    wr(0, 18'h1);
    src_i[0] = 1; ack_i = 1; ack_src_i = 0;
    @(negedge clk);
    ack_i = 0;
    chk("R8 edge beats ack", flag_o, 18'h1);
    src_i[0] = 0;
    wr(1, ALL);
    chk("R8 cleared after", flag_o, 0);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule